// File: doc/BRIEF.md
# Breaker Failure Detection Logic

This block decides, for one circuit breaker, that the breaker has not cleared a fault after the protection asked it to open. It works on sampled logic flags, not on measured current. For each phase it takes an instantaneous overcurrent flag and a failure-initiation flag. It also takes two programmable pickup delays, both counted in enabled clock ticks.

The block has two detection paths. The multiphase path keeps one first-stage pickup timer per phase. It raises a single three-pole failure output when a phase's timer has run out, that phase still carries overcurrent, and at least two of the three phases are initiated. The single-pole path adds a second pickup timer per phase, and that timer starts only once the first has run out, so the two delays add up. A phase's single-pole failure output rises when its second timer has run out, the phase still carries overcurrent, and neither of the other two phases is initiated.

Downstream trip logic uses the three-pole output after a three-pole trip. It uses the per-phase outputs after a single-pole trip, and the second delay lets it grade the two cases against each other.

Top module: `bf_detect`

## Requirements
- R1: Each phase has a first-stage timer that counts enabled ticks while that phase's initiation flag is high, and stops at the first setting (`pu1_set`). It has run out once its count has reached the setting.
- R2: `fail_3p` is high one clock after a cycle in which two conditions hold together: some phase's first-stage timer has run out while that phase's overcurrent flag is high, and at least two of the three initiation flags are high. With ticks on every cycle and inputs held from a given edge, it first reads high `pu1_set`+1 edges later.
- R3: If a phase's overcurrent flag drops before its first-stage timer runs out, and the flag stays low, no failure output rises for that phase.
- R4: A phase's second-stage timer counts only while that phase's first-stage timer has run out, and stops at `pu2_set`. With ticks on every cycle, `fail_1p[p]` first reads high `pu1_set`+`pu2_set`+1 edges after initiation.
- R5: `fail_1p[p]` is high only when the phase's second-stage timer has run out, `oc[p]` is high, and neither of the other two initiation flags is high. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C, for `oc`, `init` and `fail_1p`.
- R6: A setting of zero makes its timer run out in the same cycle its run condition is first true. With both settings zero, an output rises one edge after its inputs are applied.
- R7: Timers advance only on cycles with `tick_en` high. With `tick_en` low, a non-zero delay never runs out.
- R8: While the inputs stay in a failure state, the timers hold at the setting and do not wrap, so the output stays high.
- R9: When an initiation flag drops, that phase's timers clear to zero. A later initiation runs the full delay again.
- R10: Synchronous reset, active high, clears all timers and outputs. The outputs stay low until a detection condition is met again.

Bit mapping: bit 0 = phase A, bit 1 = phase B, bit 2 = phase C. This holds for `oc`, `init` and `fail_1p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer advance strobe |
| oc | input | 3 | Per-phase overcurrent flags (bit 0 = A) |
| init | input | 3 | Per-phase failure-initiation flags (bit 0 = A) |
| pu1_set | input | CNT_W | First-stage pickup delay in ticks |
| pu2_set | input | CNT_W | Second-stage pickup delay in ticks |
| fail_3p | output | 1 | Three-pole (multiphase) failure, registered |
| fail_1p | output | 3 | Per-phase single-pole failure, registered |

## Verification
With a tick on every cycle, `fail_3p` is due `pu1_set`+1 edges after the inputs are applied, and `fail_1p[p]` is due `pu1_set`+`pu2_set`+1 edges after. With both settings zero, both are due one edge after. The bench changes inputs on the falling edge and counts rising edges exactly. It samples on the following falling edge, and checks each output low one edge before its due edge and high at it. Tests of drop-out, vote blocking and tick gating hold their inputs well past the due edge and then confirm that the outputs stay low.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int NPH = 3;

  // true when at least two of the three flags are set
  function automatic logic vote2(input logic [NPH-1:0] f);
    return (f[0] & f[1]) | (f[1] & f[2]) | (f[0] & f[2]);
  endfunction
endpackage

// File: rtl/bf_pickup_timer.sv
module bf_pickup_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             run,
  input  logic [CNT_W-1:0] setting,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick_en && (cnt < setting))
      cnt <= cnt + 1'b1;
  end

  // >= keeps a lowered setting safe; a zero setting expires at once
  assign expired = run && (cnt >= setting);
endmodule

// File: rtl/bf_multi_path.sv
module bf_multi_path
  import bf_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] stage1_done,
  input  logic [NPH-1:0] oc,
  input  logic [NPH-1:0] init,
  output logic           fail_3p
);
  logic hit;

  assign hit = vote2(init) && (|(stage1_done & oc));

  always_ff @(posedge clk) begin
    if (rst) fail_3p <= 1'b0;
    else     fail_3p <= hit;
  end
endmodule

// File: rtl/bf_single_path.sv
module bf_single_path #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             stage1_done,
  input  logic             oc_self,
  input  logic [1:0]       init_others,
  input  logic [CNT_W-1:0] pu2_set,
  output logic             fail_1p
);
  logic stage2_done;

  bf_pickup_timer #(.CNT_W(CNT_W)) i_stage2 (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .run     (stage1_done),
    .setting (pu2_set),
    .expired (stage2_done)
  );

  always_ff @(posedge clk) begin
    if (rst) fail_1p <= 1'b0;
    else     fail_1p <= stage2_done && oc_self && (init_others == 2'b00);
  end
endmodule

// File: rtl/bf_detect.sv
module bf_detect
  import bf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [2:0]       oc,
  input  logic [2:0]       init,
  input  logic [CNT_W-1:0] pu1_set,
  input  logic [CNT_W-1:0] pu2_set,
  output logic             fail_3p,
  output logic [2:0]       fail_1p
);
  logic [NPH-1:0] stage1_done;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    bf_pickup_timer #(.CNT_W(CNT_W)) i_stage1 (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .run     (init[p]),
      .setting (pu1_set),
      .expired (stage1_done[p])
    );

    bf_single_path #(.CNT_W(CNT_W)) i_single (
      .clk         (clk),
      .rst         (rst),
      .tick_en     (tick_en),
      .stage1_done (stage1_done[p]),
      .oc_self     (oc[p]),
      .init_others ({init[(p+2)%NPH], init[(p+1)%NPH]}),
      .pu2_set     (pu2_set),
      .fail_1p     (fail_1p[p])
    );
  end

  bf_multi_path i_multi (
    .clk         (clk),
    .rst         (rst),
    .stage1_done (stage1_done),
    .oc          (oc),
    .init        (init),
    .fail_3p     (fail_3p)
  );
endmodule

// File: rtl/bf_detect_chk.sv
module bf_detect_chk
  import bf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       oc,
  input logic [2:0]       init,
  input logic [CNT_W-1:0] pu1_set,
  input logic [CNT_W-1:0] pu2_set,
  input logic             fail_3p,
  input logic [2:0]       fail_1p
);
  // R2: three-pole output needs a two-of-three vote on the previous cycle
  a_r2_vote: assert property (@(posedge clk) disable iff (rst)
    fail_3p |-> $past(vote2(init)));

  // R3: three-pole output needs an initiated phase carrying overcurrent
  a_r3_oc_held: assert property (@(posedge clk) disable iff (rst)
    fail_3p |-> $past(|(oc & init)));

  // R5: single-pole outputs need own overcurrent and no other initiation
  a_r5_phase_a: assert property (@(posedge clk) disable iff (rst)
    fail_1p[0] |-> $past(oc[0] && init[0] && !init[1] && !init[2]));
  a_r5_phase_b: assert property (@(posedge clk) disable iff (rst)
    fail_1p[1] |-> $past(oc[1] && init[1] && !init[0] && !init[2]));
  a_r5_phase_c: assert property (@(posedge clk) disable iff (rst)
    fail_1p[2] |-> $past(oc[2] && init[2] && !init[0] && !init[1]));

  // R6: zero settings give a single-pole output one edge later
  a_r6_zero_delay: assert property (@(posedge clk) disable iff (rst)
    (pu1_set == '0 && pu2_set == '0 && init == 3'b001 && oc == 3'b001)
      |=> fail_1p[0]);

  // R10: reset clears the outputs
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!fail_3p && fail_1p == 3'b000));
endmodule

bind bf_detect bf_detect_chk #(.CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .oc      (oc),
  .init    (init),
  .pu1_set (pu1_set),
  .pu2_set (pu2_set),
  .fail_3p (fail_3p),
  .fail_1p (fail_1p)
);

// File: tb/test_bf_detect.sv
`timescale 1ns/100ps
module test_bf_detect;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_en = 1'b1;
  logic [2:0]       oc = '0;
  logic [2:0]       init = '0;
  logic [CNT_W-1:0] pu1_set = 16'd3;
  logic [CNT_W-1:0] pu2_set = 16'd2;
  logic             fail_3p;
  logic [2:0]       fail_1p;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bf_detect #(.CNT_W(CNT_W)) i_bf_detect (
    .clk(clk), .rst(rst), .tick_en(tick_en), .oc(oc), .init(init),
    .pu1_set(pu1_set), .pu2_set(pu2_set), .fail_3p(fail_3p), .fail_1p(fail_1p)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input logic [15:0] s1, input logic [15:0] s2);
    init = '0; oc = '0; tick_en = 1'b1; pu1_set = s1; pu2_set = s2;
    step(2);
  endtask

  task automatic t_reset;
    chk("R10 reset 3p", {3'b0, fail_3p}, 4'd0);
    chk("R10 reset 1p", {1'b0, fail_1p}, 4'd0);
  endtask

  task automatic t_multi;
    idle(3, 2);
    init = 3'b011; oc = 3'b011;
    step(3);
    chk("R2 early", {3'b0, fail_3p}, 4'd0);
    step(1);
    chk("R2 due", {3'b0, fail_3p}, 4'd1);
    step(40);
    chk("R8 held", {3'b0, fail_3p}, 4'd1);
    chk("R5 vote blocks 1p", {1'b0, fail_1p}, 4'd0);
  endtask

  task automatic t_dropout;
    idle(3, 2);
    init = 3'b011; oc = 3'b011;
    step(2);
    oc = 3'b000;
    step(8);
    chk("R3 dropout 3p", {3'b0, fail_3p}, 4'd0);
    chk("R3 dropout 1p", {1'b0, fail_1p}, 4'd0);
  endtask

  task automatic t_single;
    idle(3, 2);
    init = 3'b010; oc = 3'b010;
    step(5);
    chk("R4 early", {1'b0, fail_1p}, 4'd0);
    step(1);
    chk("R4 due", {1'b0, fail_1p}, 4'b0010);
    chk("R2 single no 3p", {3'b0, fail_3p}, 4'd0);
  endtask

  task automatic t_other_init;
    idle(3, 2);
    init = 3'b101; oc = 3'b100;
    step(10);
    chk("R5 other init blocks", {1'b0, fail_1p}, 4'd0);
    chk("R2 vote with C oc", {3'b0, fail_3p}, 4'd1);
  endtask

  task automatic t_zero;
    idle(0, 0);
    init = 3'b001; oc = 3'b001;
    step(1);
    chk("R6 zero delay 1p", {1'b0, fail_1p}, 4'b0001);
    idle(0, 0);
    init = 3'b110; oc = 3'b100;
    step(1);
    chk("R6 zero delay 3p", {3'b0, fail_3p}, 4'd1);
  endtask

  task automatic t_tick;
    idle(3, 0);
    tick_en = 1'b0;
    init = 3'b011; oc = 3'b011;
    step(10);
    chk("R7 no tick", {3'b0, fail_3p}, 4'd0);
    tick_en = 1'b1;
    step(3);
    chk("R7 tick early", {3'b0, fail_3p}, 4'd0);
    step(1);
    chk("R7 tick due", {3'b0, fail_3p}, 4'd1);
  endtask

  task automatic t_restart;
    idle(3, 2);
    init = 3'b011; oc = 3'b011;
    step(2);
    init = 3'b000;
    step(1);
    init = 3'b011;
    step(3);
    chk("R9 restart early", {3'b0, fail_3p}, 4'd0);
    step(1);
    chk("R9 restart due", {3'b0, fail_3p}, 4'd1);
    chk("R1 timer full count", {3'b0, fail_3p}, 4'd1);
  endtask

  task automatic t_reset_mid;
    idle(3, 2);
    init = 3'b011; oc = 3'b011;
    step(6);
    rst = 1'b1;
    step(1);
    chk("R10 sync reset", {3'b0, fail_3p}, 4'd0);
    rst = 1'b0;
    step(3);
    chk("R10 stays low", {3'b0, fail_3p}, 4'd0);
    step(1);
    chk("R10 after reset due", {3'b0, fail_3p}, 4'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst = 1'b0;
    step(1);
    t_multi();
    t_dropout();
    t_single();
    t_other_init();
    t_zero();
    t_tick();
    t_restart();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule